// File: doc/BRIEF.md
# Address Decoder with Faulty-Block Overlay

This block turns a 20-bit processor address and a memory/IO strobe into active-low chip selects for two memory devices. A 64KB main device occupies 70000H to 7FFFFH. Part of that device, 73210H to 73317H, is known to be bad. A 512-byte substitute device is therefore laid over the aligned window 73200H to 733FFH. Inside that window the substitute is selected and the main device is not.

The block is purely combinational. It has no state machine and no clock. Each device also receives its local address, which is the low address lines that the device decodes internally.

A parameter chooses between two decoding styles:

- **Full decoding:** every upper line is compared, so each byte has exactly one address.
- **Partial decoding:** the most significant line A19 is left out of the compare. Each device then also answers at a mirrored image 80000H higher (F0000H to FFFFFH for main, F3200H to F33FFH for the substitute).

Top module: `overlay_mem_decoder`

## Requirements
- R1: When `mem_io` is 0 (IO access), `main_cs_n` and `spare_cs_n` are both 1 for every address.
- R2: In a memory access (`mem_io`=1), any address in 70000H..7FFFFH outside 73200H..733FFH drives `main_cs_n`=0 and `spare_cs_n`=1.
- R3: In a memory access, any address in 73200H..733FFH drives `spare_cs_n`=0 and `main_cs_n`=1. This window covers the faulty span 73210H..73317H and its edges 73200H and 733FFH.
- R4: `main_cs_n` and `spare_cs_n` are never both 0.
- R5: `main_addr` always equals addr[15:0] and `spare_addr` always equals addr[8:0].
- R6: With full decoding, a memory access outside 70000H..7FFFFH leaves both selects at 1.
- R7: With partial decoding, A19 is ignored. An address behaves exactly like the same address with A19 cleared, so images appear at F0000H..FFFFFH with the overlay at F3200H..F33FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_io | input | 1 | 1 = memory access, 0 = IO access |
| addr | input | 20 | Processor address |
| main_cs_n | output | 1 | Active-low select of the 64KB main device |
| main_addr | output | 16 | Local address of the main device |
| spare_cs_n | output | 1 | Active-low select of the 512B substitute device |
| spare_addr | output | 9 | Local address of the substitute device |

## Verification
The bench sweeps the window boundaries byte by byte: 731FFH, 73200H, 733FFH and 73400H, plus the whole faulty span. It also strides through the full 1MB space in both decoding modes, and runs the same sweep with the strobe in IO mode.

Each of these checks catches a specific mistake:

- **Window one byte off, or only covering the faulty span:** the sweep finds main selected at 73200H, or the substitute selected at 73400H.
- **Missing priority gate:** both selects go low together inside the window.
- **Upper line dropped in full mode:** selects appear at a mirror such as F3200H.
- **Strobe ignored:** a select goes low during IO access.
- **A19 still compared in partial mode:** the high images never answer.

// File: rtl/overlay_dec_pkg.sv
package overlay_dec_pkg;
    localparam int unsigned ADDR_W = 20;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_MAIN  = 2'd1,
        HIT_SPARE = 2'd2
    } hit_kind_e;
endpackage

// File: rtl/window_match.sv
module window_match #(
    parameter int unsigned AW      = 20,
    parameter int unsigned SIZE_LG = 16,
    parameter logic [AW-1:0] BASE  = 20'h70000,
    parameter logic [AW-1:0] IGNORE = '0,
    parameter bit FULL            = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int unsigned TAG_W = AW - SIZE_LG;
    localparam logic [AW-1:0] KEEP = FULL ? {AW{1'b1}} : ~IGNORE;
    localparam logic [AW-1:0] REF  = BASE & KEEP;

    logic [AW-1:0]    masked;
    logic [TAG_W-1:0] tag_in;
    logic [TAG_W-1:0] tag_ref;

    assign masked  = addr & KEEP;
    assign tag_in  = masked[AW-1:SIZE_LG];
    assign tag_ref = REF[AW-1:SIZE_LG];

    generate
        if (FULL) begin : g_full
            assign hit = (addr[AW-1:SIZE_LG] == tag_ref);
        end else begin : g_partial
            assign hit = (tag_in == tag_ref);
        end
    endgenerate
endmodule

// File: rtl/select_priority.sv
module select_priority
    import overlay_dec_pkg::*;
(
    input  logic      strobe_mem,
    input  logic      main_hit,
    input  logic      spare_hit,
    output hit_kind_e winner
);
    always_comb begin
        winner = HIT_NONE;
        if (strobe_mem) begin
            if (spare_hit)     winner = HIT_SPARE;
            else if (main_hit) winner = HIT_MAIN;
        end
    end
endmodule

// File: rtl/overlay_mem_decoder.sv
module overlay_mem_decoder
    import overlay_dec_pkg::*;
#(
    parameter bit          FULL_DECODE = 1'b1,
    parameter int unsigned MAIN_LG     = 16,
    parameter int unsigned SPARE_LG    = 9,
    parameter logic [19:0] MAIN_BASE   = 20'h70000,
    parameter logic [19:0] SPARE_BASE  = 20'h73200,
    parameter logic [19:0] MIRROR_MASK = 20'h80000
) (
    input  logic                mem_io,
    input  logic [19:0]         addr,
    output logic                main_cs_n,
    output logic [MAIN_LG-1:0]  main_addr,
    output logic                spare_cs_n,
    output logic [SPARE_LG-1:0] spare_addr
);
    logic      main_hit;
    logic      spare_hit;
    hit_kind_e winner;

    window_match #(
        .AW(ADDR_W), .SIZE_LG(MAIN_LG), .BASE(MAIN_BASE),
        .IGNORE(MIRROR_MASK), .FULL(FULL_DECODE)
    ) u_main_match (
        .addr(addr), .hit(main_hit)
    );

    window_match #(
        .AW(ADDR_W), .SIZE_LG(SPARE_LG), .BASE(SPARE_BASE),
        .IGNORE(MIRROR_MASK), .FULL(FULL_DECODE)
    ) u_spare_match (
        .addr(addr), .hit(spare_hit)
    );

    select_priority u_prio (
        .strobe_mem(mem_io),
        .main_hit  (main_hit),
        .spare_hit (spare_hit),
        .winner    (winner)
    );

    always_comb begin
        main_cs_n  = 1'b1;
        spare_cs_n = 1'b1;
        unique case (winner)
            HIT_MAIN:  main_cs_n  = 1'b0;
            HIT_SPARE: spare_cs_n = 1'b0;
            default:   ;
        endcase
    end

    assign main_addr  = addr[MAIN_LG-1:0];
    assign spare_addr = addr[SPARE_LG-1:0];

    always_comb begin
        p_io_idle_r1: assert (mem_io || (main_cs_n && spare_cs_n))
            else $error("IO access selected a device");
        p_cs_exclusive_r4: assert (main_cs_n || spare_cs_n)
            else $error("both selects active");
        p_spare_over_main_r3: assert (!(mem_io && spare_hit) || (!spare_cs_n && main_cs_n))
            else $error("overlay did not take priority");
        p_local_addr_r5: assert (spare_addr == main_addr[SPARE_LG-1:0])
            else $error("local address bits disagree");
    end
endmodule

// File: tb/tb_overlay_mem_decoder.sv
module tb_overlay_mem_decoder;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        mem_io;
    logic [19:0] addr;
    logic        f_main_n, f_spare_n, p_main_n, p_spare_n;
    logic [15:0] f_maddr, p_maddr;
    logic [8:0]  f_saddr, p_saddr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    overlay_mem_decoder #(.FULL_DECODE(1'b1)) dut (
        .mem_io(mem_io), .addr(addr),
        .main_cs_n(f_main_n), .main_addr(f_maddr),
        .spare_cs_n(f_spare_n), .spare_addr(f_saddr)
    );

    overlay_mem_decoder #(.FULL_DECODE(1'b0)) dut_p (
        .mem_io(mem_io), .addr(addr),
        .main_cs_n(p_main_n), .main_addr(p_maddr),
        .spare_cs_n(p_spare_n), .spare_addr(p_saddr)
    );

    function automatic string tag_of(input logic m, input logic [19:0] a, input bit full);
        logic [19:0] e;
        e = full ? a : (a & 20'h7FFFF);
        if (!m)                              return "R1";
        if (!full && a[19])                  return "R7";
        if (e >= 20'h73200 && e <= 20'h733FF) return "R3";
        if (e >= 20'h70000 && e <= 20'h7FFFF) return "R2";
        return "R6";
    endfunction

    task automatic check_point(input logic m, input logic [19:0] a);
        for (int k = 0; k < 2; k++) begin
            bit          full;
            logic [19:0] e;
            logic        exp_s, exp_m, got_m, got_s;
            logic [15:0] ma;
            logic [8:0]  sa;
            full  = (k == 0);
            e     = full ? a : (a & 20'h7FFFF);
            exp_s = !(m && e >= 20'h73200 && e <= 20'h733FF);
            exp_m = !(m && e >= 20'h70000 && e <= 20'h7FFFF) || !exp_s;
            got_m = full ? f_main_n : p_main_n;
            got_s = full ? f_spare_n : p_spare_n;
            ma    = full ? f_maddr : p_maddr;
            sa    = full ? f_saddr : p_saddr;
            total++;
            if (got_m !== exp_m || got_s !== exp_s) begin
                bad++;
                $display("FAIL %s full=%0d addr=%05h io=%0d cs_n main/spare got=%b%b exp=%b%b",
                         tag_of(m, a, full), full, a, m, got_m, got_s, exp_m, exp_s);
            end
            total++;
            if (!got_m && !got_s) begin
                bad++;
                $display("FAIL R4 addr=%05h both selects low got=00 exp=not 00", a);
            end
            total++;
            if (ma !== a[15:0] || sa !== a[8:0]) begin
                bad++;
                $display("FAIL R5 addr=%05h local got=%04h/%03h exp=%04h/%03h",
                         a, ma, sa, a[15:0], a[8:0]);
            end
        end
    endtask

    task automatic apply(input logic m, input logic [19:0] a);
        mem_io = m;
        addr   = a;
        #2;
        check_point(m, a);
        #1;
    endtask

    initial begin
        mem_io = 1'b0;
        addr   = 20'h73250;
        #3;
        check_point(1'b0, 20'h73250);   // R1 idle state at start

        // R3 / R2 window edges, exact bytes
        apply(1'b1, 20'h731FF);
        apply(1'b1, 20'h73200);
        apply(1'b1, 20'h73210);
        apply(1'b1, 20'h73317);
        apply(1'b1, 20'h733FF);
        apply(1'b1, 20'h73400);
        // R6 / R7 outside the main range and the mirrors
        apply(1'b1, 20'h6FFFF);
        apply(1'b1, 20'h80000);
        apply(1'b1, 20'hF3200);
        apply(1'b1, 20'hF31FF);
        apply(1'b1, 20'hFFFFF);
        apply(1'b1, 20'h00000);

        // dense sweep around the overlay, both strobes
        for (int a = 32'h73000; a < 32'h73600; a++) apply(1'b1, 20'(a));
        for (int a = 32'hF3100; a < 32'hF3500; a++) apply(1'b1, 20'(a));
        for (int a = 32'h73180; a < 32'h73480; a++) apply(1'b0, 20'(a));

        // strided sweep of the whole space
        for (int a = 0; a < 32'h100000; a += 32'h107) begin
            apply(1'b1, 20'(a));
            apply(1'b0, 20'(a));
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule